// File: doc/BRIEF.md
# CCD Line Transfer Sequencer

This block drives the phase clocks of an interline CCD that has two horizontal shift registers, A and B. Each frame opens with a wait, then a long pulse that moves photodiode charge into the vertical registers. After that the block steps through the lines. Each pass performs one or two vertical-to-horizontal transfers and then, unless the pass is dumped, a horizontal readout. All outputs are logic-level phase signals. Level shifting and clock drivers sit outside the block.

Three readout modes exist. Single mode reads each line through register A only. Dual mode loads a line into A and hands it over to B. It then loads the next line into A and shifts both registers out together. Binning mode merges two line transfers in register A and reads them out as one line. A dump request clears the lines of a pass through the dump-gate output, and such a pass is never shifted out. Every duration is a parameter given as a count of reference clock cycles.

Top module: `ccd_line_seq`

## Requirements
- R1: While reset is held and while idle, v1_o=1, v2_o=0, pd_xfer_o=0, h1a_o=1, h1b_o=0, h2_o=0, fdg_o=0 and line_valid_o=0. Both counters read zero after reset, and no phase moves until sof_i is seen.
- R2: A frame starts on sof_i sampled high while idle. A wait of at least T_RD cycles follows, then pd_xfer_o is high for exactly T_PD cycles.
- R3: A line transfer holds v2_o high for exactly T_V cycles and then v1_o high for T_V cycles. v1_o and v2_o are always complementary. h1a_o is high and h2_o is low whenever v2_o is high.
- R4: In single mode, each transfer is followed by one readout and h1b_o stays low for the whole frame.
- R5: In dual mode, the first transfer of a pass is followed by a handoff in which h1a_o is low, h1b_o is high and h2_o is low for exactly T_AB cycles. h1a_o then returns high and the second transfer loads A. One readout then clocks h1a_o and h1b_o together.
- R6: In binning mode, each pass makes two transfers into A with no handoff, followed by one readout, and h1b_o stays low.
- R7: A readout starts T_V+T_HD cycles after the last V2 falling edge of its pass. It lasts 2*HPIX cycles with line_valid_o high and carries exactly HPIX h2_o pulses. h2_o is never high together with h1a_o or h1b_o.
- R8: In a dumped pass, fdg_o rises in the same cycle as v2_o. It stays high for exactly T_FDG cycles after each V2 falling edge, then falls while v2_o is low and before the next V2 rising edge. No readout happens and line_valid_o stays low.
- R9: dump_req_i is sampled once, at the start of each pass. A change during a pass does not affect that pass.
- R10: A frame ends after LINES vertical transfers. frame_done_o then pulses for one cycle, frame_cnt_o increments, line_cnt_o holds LINES and the block returns to idle.
- R11: sof_i pulses during a frame are ignored. The frame's transfer count and its single frame_done_o pulse are unchanged.
- R12: mode_i is latched at frame start and a change during the frame has no effect. The encodings are 0 for single, 1 for dual, 2 for binning and 3 for single.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame strobe |
| mode_i | input | 2 | Readout mode select |
| dump_req_i | input | 1 | Dump request, sampled per pass |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| pd_xfer_o | output | 1 | Photodiode-to-vertical transfer level on phase 1 |
| h1a_o | output | 1 | Horizontal phase 1, register A |
| h1b_o | output | 1 | Horizontal phase 1, register B |
| h2_o | output | 1 | Horizontal phase 2, shared |
| fdg_o | output | 1 | Fast dump gate |
| line_valid_o | output | 1 | High while a non-dumped line shifts out |
| frame_done_o | output | 1 | One-cycle pulse at frame end |
| line_cnt_o | output | $clog2(LINES+1) | Vertical transfers done in this frame |
| frame_cnt_o | output | FRAME_W | Completed frames, wrapping |

## Verification
The hardest case to reach is a frame in which only some passes are dumped. The dump request is sampled once per pass, so stimulus that changes at an arbitrary edge cannot say which pass it hits. The bench holds the dump request high from frame start until it sees the first V2 pulse at the ports, then drops it. This gives exactly one dumped pass followed by normal passes. A second awkward case is a start strobe together with a mode change in the middle of a frame. It is driven once a chosen number of V2 pulses has been seen, and the bench then confirms that no handoff appears and that the frame length is unchanged.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE     = 2'd0,
    MODE_DUAL       = 2'd1,
    MODE_BIN        = 2'd2,
    MODE_SINGLE_ALT = 2'd3
  } ccd_mode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RDLY,
    S_PDX,
    S_V2H,
    S_V1H,
    S_ABX,
    S_HDLY,
    S_SHIFT
  } seq_state_e;

  typedef struct packed {
    logic v1;
    logic v2;
    logic pd;
    logic h1a;
    logic h1b;
    logic h2;
    logic fdg;
    logic lv;
  } phase_vec_t;

  localparam phase_vec_t PHASE_IDLE = '{v1: 1'b1, v2: 1'b0, pd: 1'b0, h1a: 1'b1,
                                        h1b: 1'b0, h2: 1'b0, fdg: 1'b0, lv: 1'b0};

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ccd_dwell_timer.sv
module ccd_dwell_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - W'(1);
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ccd_event_ctr.sv
module ccd_event_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_seq_pkg::*;
#(
  parameter int LINES   = 496,  // vertical transfers per frame, even
  parameter int HPIX    = 694,  // register positions shifted per line
  parameter int T_RD    = 400,  // readout delay before photodiode pulse
  parameter int T_PD    = 180,  // photodiode transfer pulse
  parameter int T_V     = 100,  // each vertical phase pulse
  parameter int T_HD    = 100,  // horizontal delay after last transfer
  parameter int T_AB    = 100,  // A-to-B handoff pulse
  parameter int T_FDG   = 24,   // dump gate hold after V2 fall, < T_V
  parameter int FRAME_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sof_i,
  input  logic [1:0]                   mode_i,
  input  logic                         dump_req_i,
  output logic                         v1_o,
  output logic                         v2_o,
  output logic                         pd_xfer_o,
  output logic                         h1a_o,
  output logic                         h1b_o,
  output logic                         h2_o,
  output logic                         fdg_o,
  output logic                         line_valid_o,
  output logic                         frame_done_o,
  output logic [$clog2(LINES+1)-1:0]   line_cnt_o,
  output logic [FRAME_W-1:0]           frame_cnt_o
);
  localparam int LINE_W  = $clog2(LINES + 1);
  localparam int DUR_MAX = max2(max2(max2(T_RD, T_PD), max2(T_V, T_HD)), max2(T_AB, 2 * HPIX));
  localparam int TMR_W   = $clog2(DUR_MAX + 1);

  localparam logic [TMR_W-1:0] D_RD    = TMR_W'(T_RD - 1);
  localparam logic [TMR_W-1:0] D_PD    = TMR_W'(T_PD - 1);
  localparam logic [TMR_W-1:0] D_V     = TMR_W'(T_V - 1);
  localparam logic [TMR_W-1:0] D_HD    = TMR_W'(T_HD - 1);
  localparam logic [TMR_W-1:0] D_AB    = TMR_W'(T_AB - 1);
  localparam logic [TMR_W-1:0] D_SH    = TMR_W'(2 * HPIX - 1);
  localparam logic [TMR_W-1:0] FDG_THR = TMR_W'(T_V - 1 - T_FDG);
  localparam logic [LINE_W:0]  LINES_C = (LINE_W + 1)'(LINES);
  localparam logic [LINE_W-1:0] LINES_L = LINE_W'(LINES);

  seq_state_e       state_q, state_d;
  ccd_mode_e        mode_q;
  logic             xfer_q, dump_q;
  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val, tmr;
  logic             start_pass, go_x1, pass_end, line_inc, line_clr, frame_end;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W:0]  lines_after;
  logic             frame_done_q, dual_hold;
  phase_vec_t       ph_d, ph_q;

  ccd_dwell_timer #(.W(TMR_W)) i_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (tmr_load),
    .val_i (tmr_val), .cnt_o (tmr), .done_o (tmr_done)
  );

  ccd_event_ctr #(.W(LINE_W)) i_line_ctr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (line_clr),
    .inc_i (line_inc), .cnt_o (line_cnt)
  );

  ccd_event_ctr #(.W(FRAME_W)) i_frame_ctr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (1'b0),
    .inc_i (frame_end), .cnt_o (frame_cnt_o)
  );

  assign lines_after = {1'b0, line_cnt} + {{LINE_W{1'b0}}, line_inc};

  // sequencing
  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    start_pass = 1'b0;
    go_x1      = 1'b0;
    pass_end   = 1'b0;
    line_inc   = 1'b0;
    line_clr   = 1'b0;
    frame_end  = 1'b0;
    case (state_q)
      S_IDLE: if (sof_i) begin
        state_d = S_RDLY; tmr_load = 1'b1; tmr_val = D_RD; line_clr = 1'b1;
      end
      S_RDLY: if (tmr_done) begin
        state_d = S_PDX; tmr_load = 1'b1; tmr_val = D_PD;
      end
      S_PDX: if (tmr_done) begin
        state_d = S_V2H; tmr_load = 1'b1; tmr_val = D_V; start_pass = 1'b1;
      end
      S_V2H: if (tmr_done) begin
        state_d = S_V1H; tmr_load = 1'b1; tmr_val = D_V;
      end
      S_V1H: if (tmr_done) begin
        line_inc = 1'b1;
        if (!xfer_q && mode_q != MODE_SINGLE) begin
          if (mode_q == MODE_DUAL && !dump_q) begin
            state_d = S_ABX; tmr_load = 1'b1; tmr_val = D_AB;
          end else begin
            state_d = S_V2H; tmr_load = 1'b1; tmr_val = D_V; go_x1 = 1'b1;
          end
        end else if (dump_q) begin
          pass_end = 1'b1;
        end else begin
          state_d = S_HDLY; tmr_load = 1'b1; tmr_val = D_HD;
        end
      end
      S_ABX: if (tmr_done) begin
        state_d = S_V2H; tmr_load = 1'b1; tmr_val = D_V; go_x1 = 1'b1;
      end
      S_HDLY: if (tmr_done) begin
        state_d = S_SHIFT; tmr_load = 1'b1; tmr_val = D_SH;
      end
      S_SHIFT: if (tmr_done) pass_end = 1'b1;
      default: state_d = S_IDLE;
    endcase
    if (pass_end) begin
      if (lines_after == LINES_C) begin
        state_d = S_IDLE; frame_end = 1'b1;
      end else begin
        state_d = S_V2H; tmr_load = 1'b1; tmr_val = D_V; start_pass = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      mode_q       <= MODE_SINGLE;
      xfer_q       <= 1'b0;
      dump_q       <= 1'b0;
      frame_done_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      frame_done_q <= frame_end;
      if (state_q == S_IDLE && sof_i)
        mode_q <= (mode_i == 2'd3) ? MODE_SINGLE : ccd_mode_e'(mode_i);
      if (start_pass) begin
        xfer_q <= 1'b0;
        dump_q <= dump_req_i;
      end else if (go_x1) begin
        xfer_q <= 1'b1;
      end
    end
  end

  // B holds the handed-over line until the parallel readout
  assign dual_hold = (mode_q == MODE_DUAL) && xfer_q && !dump_q;

  always_comb begin
    ph_d = PHASE_IDLE;
    case (state_q)
      S_PDX:  ph_d.pd = 1'b1;
      S_V2H: begin
        ph_d.v2  = 1'b1;
        ph_d.v1  = 1'b0;
        ph_d.fdg = dump_q;
        ph_d.h1b = dual_hold;
      end
      S_V1H: begin
        ph_d.fdg = dump_q && (tmr > FDG_THR);
        ph_d.h1b = dual_hold;
      end
      S_ABX: begin
        ph_d.h1a = 1'b0;
        ph_d.h1b = 1'b1;
      end
      S_HDLY: ph_d.h1b = dual_hold;
      S_SHIFT: begin
        ph_d.h2  = tmr[0];
        ph_d.h1a = ~tmr[0];
        ph_d.h1b = (mode_q == MODE_DUAL) && ~tmr[0];
        ph_d.lv  = 1'b1;
      end
      default: ph_d = PHASE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PHASE_IDLE;
    else         ph_q <= ph_d;
  end

  assign v1_o         = ph_q.v1;
  assign v2_o         = ph_q.v2;
  assign pd_xfer_o    = ph_q.pd;
  assign h1a_o        = ph_q.h1a;
  assign h1b_o        = ph_q.h1b;
  assign h2_o         = ph_q.h2;
  assign fdg_o        = ph_q.fdg;
  assign line_valid_o = ph_q.lv;
  assign frame_done_o = frame_done_q;
  assign line_cnt_o   = line_cnt;

  a_r3_v_complementary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_o != v2_o);
  a_r3_h_hold_during_v2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2_o |-> (h1a_o && !h2_o));
  a_r7_h_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(h2_o && (h1a_o || h1b_o)));
  a_r5_handoff_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!h1a_o && !line_valid_o) |-> (h1b_o && !h2_o));
  a_r4_b_low_not_dual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_DUAL) |-> !h1b_o);
  a_r8_dump_no_readout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdg_o |-> !line_valid_o);
  a_r8_dump_falls_v2_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fdg_o) |-> !v2_o);
  a_r10_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  a_r10_line_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_cnt_o <= LINES_L);

endmodule

// File: tb/test_ccd_line_seq.sv
module test_ccd_line_seq;
  localparam int LINES = 4;
  localparam int HPIX  = 5;
  localparam int T_RD  = 6;
  localparam int T_PD  = 5;
  localparam int T_V   = 4;
  localparam int T_HD  = 3;
  localparam int T_AB  = 3;
  localparam int T_FDG = 2;
  localparam int LW    = $clog2(LINES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0;
  logic [1:0] mode = 2'd0;
  logic dump = 1'b0;
  logic v1, v2, pd, h1a, h1b, h2, fdg, lv, fdone;
  logic [LW-1:0] line_cnt;
  logic [7:0] frame_cnt;

  always #5 clk = ~clk;

  ccd_line_seq #(
    .LINES(LINES), .HPIX(HPIX), .T_RD(T_RD), .T_PD(T_PD), .T_V(T_V),
    .T_HD(T_HD), .T_AB(T_AB), .T_FDG(T_FDG), .FRAME_W(8)
  ) i_ccd_line_seq (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .mode_i(mode), .dump_req_i(dump),
    .v1_o(v1), .v2_o(v2), .pd_xfer_o(pd), .h1a_o(h1a), .h1b_o(h1b), .h2_o(h2),
    .fdg_o(fdg), .line_valid_o(lv), .frame_done_o(fdone),
    .line_cnt_o(line_cnt), .frame_cnt_o(frame_cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // port monitor statistics
  int n_v2, n_lv, n_ab, n_fd, n_ovl, n_vbad, n_h1b, n_fdg_rise, n_fdg_bad, n_ab_bad;
  int v2w, v2w_min, v2w_max, pdw, pdw_last, lvw, lvw_min, lvw_max;
  int h2c, h2_min, h2_max, abw, abw_min, abw_max, fh, fh_min, fh_max;
  int sc, gap_min, gap_max, rd_cnt, rd_gap, v2_per, v2_per_min, v2_per_max;
  bit armed, ftrack;
  logic p_v2 = 1'b0, p_pd = 1'b0, p_lv = 1'b0, p_h1a = 1'b1, p_h2 = 1'b0, p_fdg = 1'b0;

  task automatic clear_stats();
    n_v2 = 0; n_lv = 0; n_ab = 0; n_fd = 0; n_ovl = 0; n_vbad = 0; n_h1b = 0;
    n_fdg_rise = 0; n_fdg_bad = 0; n_ab_bad = 0;
    v2w = 0; v2w_min = 999; v2w_max = 0; pdw = 0; pdw_last = 0;
    lvw = 0; lvw_min = 999; lvw_max = 0; h2c = 0; h2_min = 999; h2_max = 0;
    abw = 0; abw_min = 999; abw_max = 0; fh = 0; fh_min = 999; fh_max = 0;
    sc = 0; gap_min = 999; gap_max = 0; rd_cnt = 0; rd_gap = -1;
    v2_per = 0; v2_per_min = 999; v2_per_max = 0; armed = 1'b0; ftrack = 1'b0;
  endtask

  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      if (v1 == v2) n_vbad++;
      if (h2 && (h1a || h1b)) n_ovl++;
      if (h1b) n_h1b++;
      if (fdone) n_fd++;
      // vertical pulse widths
      if (v2) v2w = p_v2 ? v2w + 1 : 1;
      if (v2 && !p_v2) begin n_v2++; v2_per++; end
      if (!v2 && p_v2) begin
        if (v2w < v2w_min) v2w_min = v2w;
        if (v2w > v2w_max) v2w_max = v2w;
        sc = 1; ftrack = 1'b1; fh = fdg ? 1 : 0;
      end else begin
        if (!v2 && !lv) sc++;
        if (ftrack && fdg && !v2) fh++;
      end
      // dump gate edges
      if (fdg && !p_fdg) begin
        n_fdg_rise++;
        if (!(v2 && !p_v2)) n_fdg_bad++;
      end
      if (!fdg && p_fdg) begin
        if (v2) n_fdg_bad++;
        if (ftrack) begin
          if (fh < fh_min) fh_min = fh;
          if (fh > fh_max) fh_max = fh;
        end
      end
      if (fdg && lv) n_fdg_bad++;
      // photodiode pulse and readout delay
      if (sof && !armed && !pd) begin armed = 1'b1; rd_cnt = 0; end
      else if (armed && !pd) rd_cnt++;
      if (pd) pdw = p_pd ? pdw + 1 : 1;
      if (pd && !p_pd && armed) begin rd_gap = rd_cnt; armed = 1'b0; end
      if (!pd && p_pd) pdw_last = pdw;
      // readout windows
      if (lv && !p_lv) begin
        n_lv++;
        if (sc < gap_min) gap_min = sc;
        if (sc > gap_max) gap_max = sc;
        if (v2_per < v2_per_min) v2_per_min = v2_per;
        if (v2_per > v2_per_max) v2_per_max = v2_per;
        v2_per = 0; lvw = 0; h2c = 0;
      end
      if (lv) begin
        lvw++;
        if (h2 && !p_h2) h2c++;
      end
      if (!lv && p_lv) begin
        if (lvw < lvw_min) lvw_min = lvw;
        if (lvw > lvw_max) lvw_max = lvw;
        if (h2c < h2_min) h2_min = h2c;
        if (h2c > h2_max) h2_max = h2c;
      end
      // A-to-B handoff
      if (!h1a && !lv) begin
        abw = (p_h1a || p_lv) ? 1 : abw + 1;
        if (!h1b || h2) n_ab_bad++;
      end
      if (h1a && !p_h1a && !lv && abw > 0) begin
        n_ab++;
        if (abw < abw_min) abw_min = abw;
        if (abw > abw_max) abw_max = abw;
        abw = 0;
      end
      p_v2 = v2; p_pd = pd; p_lv = lv; p_h1a = h1a; p_h2 = h2; p_fdg = fdg;
    end
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic chk_ge(input string rq, input string what, input int act, input int lo);
    n_chk++;
    if (act < lo) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected >= %0d", rq, what, act, lo);
    end
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic wait_done(input int start);
    for (int i = 0; i < 4000 && n_fd == start; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_idle(input string rq);
    chk(rq, "idle v1", int'(v1), 1);
    chk(rq, "idle v2", int'(v2), 0);
    chk(rq, "idle h1a", int'(h1a), 1);
    chk(rq, "idle h1b/h2/fdg/lv/pd", int'({h1b, h2, fdg, lv, pd}), 0);
  endtask

  int exp_frames = 0;

  task automatic t_reset();
    check_idle("R1");
    chk("R1", "line_cnt after reset", int'(line_cnt), 0);
    chk("R1", "frame_cnt after reset", int'(frame_cnt), 0);
    clear_stats();
    repeat (20) @(negedge clk);
    chk("R1", "no V2 pulse without sof", n_v2, 0);
  endtask

  task automatic t_single();
    clear_stats();
    mode = 2'd0; dump = 1'b0;
    pulse_sof();
    wait_done(0);
    exp_frames++;
    chk_ge("R2", "readout delay", rd_gap, T_RD);
    chk("R2", "photodiode pulse width", pdw_last, T_PD);
    chk("R3", "V2 width min", v2w_min, T_V);
    chk("R3", "V2 width max", v2w_max, T_V);
    chk("R3", "V1/V2 not complementary", n_vbad, 0);
    chk("R4", "readouts", n_lv, LINES);
    chk("R4", "H1B high cycles", n_h1b, 0);
    chk("R7", "line_valid width", lvw_max, 2 * HPIX);
    chk("R7", "H2 pulses per line min", h2_min, HPIX);
    chk("R7", "H2 pulses per line max", h2_max, HPIX);
    chk("R7", "horizontal delay", gap_min, T_V + T_HD);
    chk("R7", "H overlap cycles", n_ovl, 0);
    chk("R10", "V2 pulses per frame", n_v2, LINES);
    chk("R10", "frame_done pulses", n_fd, 1);
    chk("R10", "line_cnt at end", int'(line_cnt), LINES);
    chk("R10", "frame_cnt", int'(frame_cnt), exp_frames);
    check_idle("R10");
  endtask

  task automatic t_dual();
    clear_stats();
    mode = 2'd1; dump = 1'b0;
    pulse_sof();
    wait_done(0);
    exp_frames++;
    chk("R5", "handoff pulses", n_ab, LINES / 2);
    chk("R5", "handoff width min", abw_min, T_AB);
    chk("R5", "handoff width max", abw_max, T_AB);
    chk("R5", "handoff level errors", n_ab_bad, 0);
    chk("R5", "readouts", n_lv, LINES / 2);
    chk_ge("R5", "H1B activity", n_h1b, 1);
    chk("R5", "V2 pulses per readout", v2_per_max, 2);
    chk("R7", "H2 pulses per line", h2_min, HPIX);
    chk("R7", "H overlap cycles", n_ovl, 0);
    chk("R10", "V2 pulses per frame", n_v2, LINES);
    chk("R10", "frame_cnt", int'(frame_cnt), exp_frames);
  endtask

  task automatic t_bin();
    clear_stats();
    mode = 2'd2; dump = 1'b0;
    pulse_sof();
    wait_done(0);
    exp_frames++;
    chk("R6", "readouts", n_lv, LINES / 2);
    chk("R6", "V2 pulses per readout min", v2_per_min, 2);
    chk("R6", "V2 pulses per readout max", v2_per_max, 2);
    chk("R6", "handoff pulses", n_ab, 0);
    chk("R6", "H1B high cycles", n_h1b, 0);
    chk("R10", "V2 pulses per frame", n_v2, LINES);
  endtask

  task automatic t_dump_dual();
    clear_stats();
    mode = 2'd1; dump = 1'b1;
    pulse_sof();
    wait_done(0);
    dump = 1'b0;
    exp_frames++;
    chk("R8", "readouts in dumped frame", n_lv, 0);
    chk("R8", "handoff pulses in dumped frame", n_ab, 0);
    chk("R8", "dump gate rises", n_fdg_rise, LINES);
    chk("R8", "dump gate hold min", fh_min, T_FDG);
    chk("R8", "dump gate hold max", fh_max, T_FDG);
    chk("R8", "dump gate edge errors", n_fdg_bad, 0);
    chk("R10", "V2 pulses per frame", n_v2, LINES);
    chk("R10", "frame_done pulses", n_fd, 1);
  endtask

  task automatic t_partial_dump();
    clear_stats();
    mode = 2'd0; dump = 1'b1;
    pulse_sof();
    for (int i = 0; i < 2000 && n_v2 == 0; i++) @(negedge clk);
    dump = 1'b0;
    wait_done(0);
    exp_frames++;
    chk("R9", "readouts after one dumped pass", n_lv, LINES - 1);
    chk("R9", "dump gate rises", n_fdg_rise, 1);
    chk("R8", "dump gate edge errors", n_fdg_bad, 0);
  endtask

  task automatic t_busy_sof();
    clear_stats();
    mode = 2'd0; dump = 1'b0;
    pulse_sof();
    for (int i = 0; i < 2000 && n_v2 < 2; i++) @(negedge clk);
    mode = 2'd1;
    pulse_sof();
    wait_done(0);
    exp_frames++;
    mode = 2'd0;
    chk("R11", "V2 pulses with extra sof", n_v2, LINES);
    chk("R11", "frame_done pulses", n_fd, 1);
    chk("R11", "line_cnt at end", int'(line_cnt), LINES);
    chk("R12", "handoffs after mid-frame mode change", n_ab, 0);
    chk("R12", "H1B after mid-frame mode change", n_h1b, 0);
    chk("R12", "readouts keep single mode", n_lv, LINES);
  endtask

  task automatic t_mode3();
    clear_stats();
    mode = 2'd3; dump = 1'b0;
    pulse_sof();
    wait_done(0);
    exp_frames++;
    mode = 2'd0;
    chk("R12", "mode 3 readouts", n_lv, LINES);
    chk("R12", "mode 3 H1B high cycles", n_h1b, 0);
    chk("R10", "frame_cnt", int'(frame_cnt), exp_frames);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
        summary();
      end
    end
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    t_reset_pre();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_dual();
    t_bin();
    t_dump_dual();
    t_partial_dump();
    t_busy_sof();
    t_mode3();
    summary();
  end

  task automatic t_reset_pre();
    check_idle("R1");
  endtask

endmodule